// File: doc/BRIEF.md
# SDRAM Burst Data Path with Data Masking

This block is a synthesizable device-side model of the data path of a synchronous DRAM. On every rising clock edge it decodes a command from the active-low chip select, row strobe, column strobe and write enable. READ and WRITE commands start fixed-length bursts against a small internal array that is organised as banks of columns. No-operation cycles, deselect cycles and every other command code leave a running burst alone.

A single mask input gates the data. On a write beat it blocks the word sampled in that same cycle. On a read it switches off the output drive of the data slot two clocks later, and that delay is the same whatever the CAS latency. Read data leaves a register. A separate output enable models the tri-state drive, and the data bus is held at zero whenever it is not driven.

Burst length and CAS latency are fixed by parameters. Row activation, refresh, precharge timing and mode programming are not part of the block.

Top module: `sdram_burst_dp`

## Requirements
- R1: Command decode at the rising edge uses {cs_ni, ras_ni, cas_ni, we_ni}. The pattern 0,1,0,1 is READ, 0,1,0,0 is WRITE and 0,1,1,1 is NOP. Every other pattern with cs_ni low starts no burst.
- R2: With cs_ni high the cycle is a deselect. It acts exactly like a NOP whatever ras_ni, cas_ni and we_ni are.
- R3: NOP, deselect and non-burst commands do not stop a running burst. A burst issues exactly BL beats (default 4): the command edge plus the BL-1 edges after it.
- R4: On a WRITE, wdata_i sampled at the command edge goes to the command column. The words sampled at the next BL-1 edges go to the following burst columns of the same bank. The array address is bank*2^COL_W + column.
- R5: A word sampled with dqm_i high on a write beat edge is not written. Its array location keeps its old value, and the other beats are unaffected.
- R6: Read data for the beat issued at edge k is driven after edge k+CL (default CL = 2). The words of a burst occupy consecutive cycles.
- R7: dqm_i high at edge j disables the read slot driven after edge j+2. This holds for any CL, and the data in that slot is lost.
- R8: Burst column order is sequential within the aligned block of BL columns and wraps at its boundary. For example, start column 6 with BL 4 gives 6, 7, 4, 5.
- R9: A READ or WRITE issued during a burst ends the old burst and starts the new one from its own column. Read beats issued before that edge still reach the bus.
- R10: rdata_oe_o is high only for unmasked read slots. rdata_o is zero whenever rdata_oe_o is low. Slot data is the array content just before the output edge.
- R11: Reset clears the array to zero, cancels any burst and leaves rdata_oe_o low with rdata_o zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every command is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | BANK_W (2) | Bank address of a READ or WRITE |
| col_i | input | COL_W (4) | Start column of a READ or WRITE |
| dqm_i | input | 1 | Data mask: blocks a write beat at once, blanks a read slot two clocks later |
| wdata_i | input | DATA_W (16) | Write data |
| rdata_o | output | DATA_W (16) | Registered read data, zero while undriven |
| rdata_oe_o | output | 1 | Output drive enable for rdata_o |

## Verification
The assertions expect the command and mask pins to hold known 0/1 values at every sampled edge after reset. This matters because the mask-delay and continuation properties compare sampled values across edges. The bench drives every input from time zero and changes inputs only on falling edges, so each edge sees settled values. The random phase draws READ, WRITE, NOP, deselect with random strobes and the other command codes. It also draws mask bits and overlapping commands, so interruption and wrap cases come up often without leaving the legal pin encodings.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_OTHER = 2'd3
  } sdram_cmd_e;

  function automatic sdram_cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
    sdram_cmd_e c;
    if (cs_n)                             c = CMD_IDLE;   // deselect
    else if ({ras_n, cas_n, we_n} == 3'b101) c = CMD_READ;
    else if ({ras_n, cas_n, we_n} == 3'b100) c = CMD_WRITE;
    else if ({ras_n, cas_n, we_n} == 3'b111) c = CMD_IDLE;   // nop
    else                                  c = CMD_OTHER;
    return c;
  endfunction

endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_dp_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic rd_o,
  output logic wr_o
);

  sdram_cmd_e cmd;

  always_comb begin
    cmd  = decode_cmd(cs_ni, ras_ni, cas_ni, we_ni);
    rd_o = (cmd == CMD_READ);
    wr_o = (cmd == CMD_WRITE);
  end

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int BL     = 4,
  localparam int AW    = BANK_W + COL_W,
  localparam int CNT_W = $clog2(BL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_rd_i,
  input  logic              cmd_wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              beat_vld_o,
  output logic              beat_wr_o,
  output logic [AW-1:0]     beat_addr_o
);

  localparam logic [COL_W-1:0] OFS_MSK  = COL_W'(BL - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BL - 1);

  logic              act_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              start;
  logic [COL_W-1:0]  cont_col;

  always_comb begin
    start    = cmd_rd_i | cmd_wr_i;
    // wrap inside the aligned block of BL columns
    cont_col = (col_q & ~OFS_MSK) | ((col_q + COL_W'(cnt_q)) & OFS_MSK);
    beat_vld_o  = start | act_q;
    beat_wr_o   = start ? cmd_wr_i : wr_q;
    beat_addr_o = start ? {bank_i, col_i} : {bank_q, cont_col};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      wr_q   <= cmd_wr_i;
      cnt_q  <= CNT_W'(1);
      bank_q <= bank_i;
      col_q  <= col_i;
    end else if (act_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST_CNT) act_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_mem_array.sv
module sdram_mem_array #(
  parameter int DATA_W = 16,
  parameter int AW     = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W  = 16,
  parameter int AW      = 6,
  parameter int CL      = 2,
  parameter int MSK_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [AW-1:0]     issue_addr_i,
  input  logic              dqm_i,
  output logic [AW-1:0]     mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);

  logic [CL-1:0]      vld_q;
  logic [AW-1:0]      addr_q [CL];
  logic [MSK_LAT-1:0] msk_q;
  logic               slot_en;
  logic [DATA_W-1:0]  data_q;
  logic               oe_q;

  // read slot pipeline, depth follows CAS latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < CL; i++) addr_q[i] <= '0;
    end else begin
      vld_q[0]  <= issue_i;
      addr_q[0] <= issue_addr_i;
      for (int i = 1; i < CL; i++) begin
        vld_q[i]  <= vld_q[i-1];
        addr_q[i] <= addr_q[i-1];
      end
    end
  end

  // mask delay line, fixed length, independent of CL
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q <= '0;
    end else begin
      msk_q[0] <= dqm_i;
      for (int i = 1; i < MSK_LAT; i++) msk_q[i] <= msk_q[i-1];
    end
  end

  assign mem_raddr_o = addr_q[CL-1];
  assign slot_en     = vld_q[CL-1] & ~msk_q[MSK_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= slot_en;
      data_q <= slot_en ? mem_rdata_i : '0;
    end
  end

  assign rdata_o = data_q;
  assign oe_o    = oe_q;

endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp #(
  parameter int DATA_W     = 16,
  parameter int BANK_W     = 2,
  parameter int COL_W      = 4,
  parameter int BL         = 4,
  parameter int CL         = 2,
  parameter int DQM_RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              dqm_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);

  localparam int AW = BANK_W + COL_W;

  logic              cmd_rd, cmd_wr;
  logic              beat_vld, beat_wr;
  logic [AW-1:0]     beat_addr;
  logic              mem_we, rd_issue;
  logic [AW-1:0]     mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  sdram_cmd_dec u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .rd_o   (cmd_rd),
    .wr_o   (cmd_wr)
  );

  sdram_burst_ctrl #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .BL     (BL)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_rd_i    (cmd_rd),
    .cmd_wr_i    (cmd_wr),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .beat_vld_o  (beat_vld),
    .beat_wr_o   (beat_wr),
    .beat_addr_o (beat_addr)
  );

  // write mask acts in the sampling cycle
  assign mem_we   = beat_vld & beat_wr & ~dqm_i;
  assign rd_issue = beat_vld & ~beat_wr;

  sdram_mem_array #(
    .DATA_W (DATA_W),
    .AW     (AW)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (beat_addr),
    .wdata_i (wdata_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  sdram_rd_pipe #(
    .DATA_W  (DATA_W),
    .AW      (AW),
    .CL      (CL),
    .MSK_LAT (DQM_RD_LAT)
  ) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (rd_issue),
    .issue_addr_i (beat_addr),
    .dqm_i        (dqm_i),
    .mem_raddr_o  (mem_raddr),
    .mem_rdata_i  (mem_rdata),
    .rdata_o      (rdata_o),
    .oe_o         (rdata_oe_o)
  );

endmodule

// File: rtl/sdram_burst_dp_chk.sv
module sdram_burst_dp_chk #(
  parameter int DATA_W     = 16,
  parameter int BL         = 4,
  parameter int CL         = 2,
  parameter int DQM_RD_LAT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              dqm_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              beat_vld,
  input logic              beat_wr
);

  logic [7:0] run_q;
  logic       cont;

  assign cont = beat_vld & ~cmd_rd & ~cmd_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (cont && run_q != '1)  run_q <= run_q + 8'd1;
    else if (!cont)                run_q <= '0;
  end

  a_r2_desel_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !(cmd_rd || cmd_wr));

  a_r3_cont_same_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont |-> ($past(beat_vld) && ($past(beat_wr) == beat_wr)));

  a_r3_burst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont |-> (run_q < 8'(BL - 1)));

  a_r7_rd_mask_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dqm_i, DQM_RD_LAT + 1) |-> !rdata_oe_o);

  a_r10_oe_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(beat_vld && !beat_wr, CL + 1));

  a_r10_undriven_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));

endmodule

bind sdram_burst_dp sdram_burst_dp_chk #(
  .DATA_W     (DATA_W),
  .BL         (BL),
  .CL         (CL),
  .DQM_RD_LAT (DQM_RD_LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .dqm_i      (dqm_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .beat_vld   (beat_vld),
  .beat_wr    (beat_wr)
);

// File: tb/tb_sdram_burst_dp.sv
module tb_sdram_burst_dp;

  localparam int DW    = 16;
  localparam int COLW  = 4;
  localparam int BL    = 4;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]    bank = '0;
  logic [3:0]    col = '0;
  logic          dqm = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd2, rd3;
  logic          oe2, oe3;

  int n_cmp = 0;
  int n_bad = 0;

  // shared model state
  logic [DW-1:0] mmem [DEPTH];
  bit            b_act, b_wr;
  int            b_cnt, b_bank, b_col;
  bit            m1, m2;
  bit            pv [2][4];
  int            pa [2][4];
  int            lat [2] = '{2, 3};

  always #2 clk = ~clk;

  sdram_burst_dp #(.CL(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .bank_i(bank), .col_i(col), .dqm_i(dqm), .wdata_i(wdata),
    .rdata_o(rd2), .rdata_oe_o(oe2)
  );

  sdram_burst_dp #(.CL(3)) dut_cl3 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .bank_i(bank), .col_i(col), .dqm_i(dqm), .wdata_i(wdata),
    .rdata_o(rd3), .rdata_oe_o(oe3)
  );

  function automatic int burst_col(int base, int off);
    return (base & ~(BL - 1)) | ((base + off) & (BL - 1));
  endfunction

  task automatic check(string tag, string who, logic [DW-1:0] got_d, logic got_oe,
                       logic [DW-1:0] exp_d, bit exp_oe);
    n_cmp++;
    if (got_oe !== exp_oe || got_d !== exp_d) begin
      n_bad++;
      $display("FAIL %s %s t=%0t: oe=%0b data=%h expected oe=%0b data=%h",
               tag, who, $time, got_oe, got_d, exp_oe, exp_d);
    end
  endtask

  task automatic cyc(bit c_cs, bit c_ras, bit c_cas, bit c_we, int bk, int cl,
                     bit dq, logic [DW-1:0] wd, string tag);
    bit            eo [2];
    logic [DW-1:0] ed [2];
    bit            isrd, iswr, bv, bw;
    int            ba;
    @(negedge clk);
    cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
    bank = 2'(bk); col = 4'(cl); dqm = dq; wdata = wd;
    @(posedge clk);
    for (int u = 0; u < 2; u++) begin
      eo[u] = pv[u][lat[u]-1] && !m2;
      ed[u] = eo[u] ? mmem[pa[u][lat[u]-1]] : '0;
    end
    isrd = !c_cs && c_ras && !c_cas && c_we;
    iswr = !c_cs && c_ras && !c_cas && !c_we;
    bv = 1'b0; bw = 1'b0; ba = 0;
    if (isrd || iswr) begin
      bv = 1'b1; bw = iswr; ba = bk * 16 + cl;
    end else if (b_act) begin
      bv = 1'b1; bw = b_wr; ba = b_bank * 16 + burst_col(b_col, b_cnt);
    end
    if (bv && bw && !dq) mmem[ba] = wd;
    if (isrd || iswr) begin
      b_act = 1'b1; b_wr = iswr; b_cnt = 1; b_bank = bk; b_col = cl;
    end else if (b_act) begin
      b_cnt++;
      if (b_cnt == BL) b_act = 1'b0;
    end
    for (int u = 0; u < 2; u++) begin
      for (int i = 3; i > 0; i--) begin
        pv[u][i] = pv[u][i-1];
        pa[u][i] = pa[u][i-1];
      end
      pv[u][0] = bv && !bw;
      pa[u][0] = ba;
    end
    m2 = m1; m1 = dq;
    #1;
    check(tag, "cl2", rd2, oe2, ed[0], eo[0]);
    check(tag, "cl3", rd3, oe3, ed[1], eo[1]);
  endtask

  task automatic nop(string tag, int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0, 0, 0, '0, tag);
  endtask

  task automatic rd(int bk, int cl, bit dq, string tag);
    cyc(0, 1, 0, 1, bk, cl, dq, '0, tag);
  endtask

  task automatic wr(int bk, int cl, logic [DW-1:0] wd, bit dq, string tag);
    cyc(0, 1, 0, 0, bk, cl, dq, wd, tag);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
    void'($urandom(32'h5d1a7c03));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R11 reset state
    check("R11", "cl2", rd2, oe2, '0, 1'b0);
    check("R11", "cl3", rd3, oe3, '0, 1'b0);

    // R11 array cleared: read unwritten column
    rd(3, 9, 0, "R11"); nop("R11", 6);

    // R4 write burst, continuation through deselect and NOP
    wr(1, 4, 16'h1100, 0, "R4");
    cyc(0, 1, 1, 1, 0, 0, 0, 16'h1101, "R4");
    cyc(1, 0, 0, 0, 2, 3, 0, 16'h1102, "R4");
    cyc(0, 1, 1, 1, 0, 0, 0, 16'h1103, "R4");
    nop("R4", 2);

    // R6 read timing, R3 burst survives deselect and other codes
    rd(1, 4, 0, "R6");
    cyc(1, 1, 0, 1, 0, 0, 0, '0, "R3");      // deselect with read pins
    cyc(0, 0, 1, 1, 0, 0, 0, '0, "R3");      // activate code
    cyc(0, 1, 1, 0, 0, 0, 0, '0, "R3");      // other code
    nop("R6", 5);

    // R5 write mask on beat 2, R8 wrap order from column 6
    wr(2, 6, 16'h2206, 0, "R5");
    cyc(0, 1, 1, 1, 0, 0, 0, 16'h2207, "R5");
    cyc(0, 1, 1, 1, 0, 0, 1, 16'h2204, "R5");
    cyc(0, 1, 1, 1, 0, 0, 0, 16'h2205, "R5");
    nop("R5", 1);
    rd(2, 6, 0, "R8"); nop("R8", 6);

    // R7 read mask two clocks later, both latencies
    rd(1, 4, 0, "R7");
    cyc(0, 1, 1, 1, 0, 0, 1, '0, "R7");
    nop("R7", 1);
    cyc(0, 1, 1, 1, 0, 0, 1, '0, "R7");
    nop("R7", 5);
    rd(2, 4, 1, "R7"); nop("R7", 6);

    // R9 interruption: read by read, then read by write
    rd(1, 4, 0, "R9");
    rd(2, 5, 0, "R9");
    nop("R9", 1);
    wr(0, 2, 16'h0a02, 0, "R9");
    cyc(0, 1, 1, 1, 0, 0, 0, 16'h0a03, "R9");
    nop("R9", 4);
    rd(0, 0, 0, "R9"); nop("R9", 6);

    // R1 non-burst codes and R2 deselect start nothing
    cyc(0, 0, 1, 1, 1, 4, 0, '0, "R1");
    cyc(0, 0, 0, 1, 1, 4, 0, '0, "R1");
    cyc(0, 0, 0, 0, 1, 4, 0, 16'hdead, "R1");
    cyc(1, 1, 0, 0, 1, 4, 0, 16'hbeef, "R2");
    cyc(1, 1, 0, 1, 1, 4, 0, '0, "R2");
    nop("R2", 4);
    rd(1, 4, 0, "R2"); nop("R2", 6);

    // R10 random traffic
    for (int n = 0; n < 3000; n++) begin
      int  sel;
      bit  dq;
      sel = $urandom_range(0, 99);
      dq  = ($urandom_range(0, 99) < 20);
      if (sel < 15)
        rd($urandom_range(0, 3), $urandom_range(0, 15), dq, "R10");
      else if (sel < 30)
        wr($urandom_range(0, 3), $urandom_range(0, 15), 16'($urandom), dq, "R10");
      else if (sel < 70)
        cyc(0, 1, 1, 1, 0, 0, dq, 16'($urandom), "R10");
      else if (sel < 85)
        cyc(1, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3),
            $urandom_range(0, 15), dq, 16'($urandom), "R10");
      else
        cyc(0, 0, 1'($urandom), 1'($urandom), $urandom_range(0, 3),
            $urandom_range(0, 15), dq, 16'($urandom), "R10");
    end
    nop("R10", 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule